// File: doc/BRIEF.md
# Saturating Vector Subtract and Horizontal Sum Unit

This unit takes two 128-bit operands, A and B. It returns one registered 128-bit result per accepted operation. Lane-wise subtraction comes in four variants:

- wrap-around (modulo)
- clamp to the signed range of the lane
- clamp to the unsigned range of the lane
- a per-word "no borrow" indicator

Two horizontal reductions treat the operands as four signed 32-bit words. One adds every A word into B word 3. The other adds adjacent A word pairs into the odd B words. Lanes that a reduction does not write come out as zero.

Any lane that clamps raises a sticky saturation status bit. The bit stays high across later operations until a clear request drops it. A datapath pipeline issues one operation per cycle with `valid_i` and sees the result on the next cycle. It reads the sticky bit at any point.

Top module: `vsub_sum_unit`

## Requirements
- R1: `op_i`=0 (wrap subtract) gives, per lane, the low lane-width bits of A minus B. The lane width comes from `size_i`: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. Lane k occupies bits k*W up to k*W+W-1.
- R2: `op_i`=1 (signed clamp subtract) gives the exact signed difference per lane, limited to the range from -2^(W-1) to 2^(W-1)-1.
- R3: `op_i`=2 (unsigned clamp subtract) gives the unsigned difference per lane, limited to the range from 0 to 2^W-1.
- R4: `op_i`=3 (no-borrow) works on 32-bit words whatever `size_i` is. Each word holds 1 when A is at least B as unsigned values, and 0 otherwise.
- R5: `op_i`=4 (full reduction) adds B word 3 (bits 127:96) and all four A words, all treated as signed. The total is clamped to the signed 32-bit range and placed in word 3. Words 0 to 2 are zero.
- R6: `op_i`=5 (pair reduction) works on each j in {0, 2}. It adds A words j and j+1 and B word j+1, all signed, and places the clamped total in word j+1. Words 0 and 2 are zero.
- R7: `sat_o` rises after an accepted operation in which any lane clamped, and then stays high. Operations 0 and 3 never raise it.
- R8: `clr_i` drops `sat_o` on the next cycle. This holds even when a clamping operation is accepted in the same cycle.
- R9: `res_o` takes the result of an operation on the clock edge at which `valid_i` is high. While `valid_i` is low it holds its value.
- R10: While `rst_ni` is low, `res_o` and `sat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation presented this cycle |
| clr_i | input | 1 | Clear the sticky saturation bit |
| op_i | input | 3 | Operation select (0 to 5) |
| size_i | input | 2 | Lane width for subtracts: 0=8, 1=16, 2/3=32 bits |
| a_i | input | 128 | Operand A |
| b_i | input | 128 | Operand B |
| res_o | output | 128 | Registered result |
| sat_o | output | 1 | Sticky saturation status |

## Verification
Each subtract variant runs on each lane width with operands whose difference crosses zero. The clamp variants also get operands that overflow in the positive or negative direction. This separates wrap-around from clamping, and signed limits from unsigned ones. One pattern alternates clamping and non-clamping bytes, which shows that lanes clamp independently.

The reductions use small mixed values to check word placement and zeroing. Extreme values in all five terms check that the sum is wide enough before clamping, in both directions.

Further sequences cover the following:
- stickiness across a non-clamping operation
- clear winning over a simultaneous clamp
- result hold with `valid_i` low
- reset in the middle of a run

// File: rtl/vsub_pkg.sv
package vsub_pkg;
  typedef enum logic [2:0] {
    OP_SUB_MOD  = 3'd0,
    OP_SUB_SSAT = 3'd1,
    OP_SUB_USAT = 3'd2,
    OP_SUB_NBRW = 3'd3,
    OP_SUM_ALL  = 3'd4,
    OP_SUM_PAIR = 3'd5
  } op_e;

  localparam int WORD_W  = 32;
  localparam int N_SIZES = 3;
endpackage

// File: rtl/vsub_lane.sv
module vsub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mod_o,
  output logic [W-1:0] ssat_o,
  output logic [W-1:0] usat_o,
  output logic         shit_o,
  output logic         uhit_o
);
  logic [W:0] sd;
  logic [W:0] ud;

  assign sd = {a_i[W-1], a_i} - {b_i[W-1], b_i};
  assign ud = {1'b0, a_i} - {1'b0, b_i};

  assign mod_o  = ud[W-1:0];
  // sign of the extended result disagrees with lane sign bit -> overflow
  assign shit_o = sd[W] ^ sd[W-1];
  assign ssat_o = shit_o ? {sd[W], {(W-1){~sd[W]}}} : sd[W-1:0];
  assign uhit_o = ud[W];
  assign usat_o = uhit_o ? '0 : ud[W-1:0];
endmodule

// File: rtl/vsum_words.sv
module vsum_words #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] all_o,
  output logic             all_hit_o,
  output logic [VEC_W-1:0] pair_o,
  output logic             pair_hit_o
);
  import vsub_pkg::*;

  localparam int N_W   = VEC_W / WORD_W;
  localparam int SUM_W = WORD_W + $clog2(N_W + 1) + 1;
  localparam int N_P   = N_W / 2;

  function automatic logic [SUM_W-1:0] sext(input logic [WORD_W-1:0] w);
    return {{(SUM_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction

  // {hit, clamped word}
  function automatic logic [WORD_W:0] clamp(input logic [SUM_W-1:0] v);
    logic [SUM_W-WORD_W:0] top;
    top = v[SUM_W-1:WORD_W-1];
    if ((&top) || !(|top)) return {1'b0, v[WORD_W-1:0]};
    return {1'b1, v[SUM_W-1], {(WORD_W-1){~v[SUM_W-1]}}};
  endfunction

  logic [SUM_W-1:0] tot;
  logic [WORD_W:0]  all_c;

  always_comb begin
    tot = sext(b_i[VEC_W-1 -: WORD_W]);
    for (int k = 0; k < N_W; k++) tot = tot + sext(a_i[k*WORD_W +: WORD_W]);
  end

  assign all_c     = clamp(tot);
  assign all_hit_o = all_c[WORD_W];
  assign all_o     = {all_c[WORD_W-1:0], {(VEC_W-WORD_W){1'b0}}};

  logic [N_P-1:0] p_hit;

  for (genvar p = 0; p < N_P; p++) begin : g_pair
    logic [SUM_W-1:0] ps;
    logic [WORD_W:0]  pc;
    assign ps = sext(a_i[2*p*WORD_W +: WORD_W]) + sext(a_i[(2*p+1)*WORD_W +: WORD_W])
              + sext(b_i[(2*p+1)*WORD_W +: WORD_W]);
    assign pc = clamp(ps);
    assign p_hit[p] = pc[WORD_W];
    assign pair_o[2*p*WORD_W +: WORD_W]     = '0;
    assign pair_o[(2*p+1)*WORD_W +: WORD_W] = pc[WORD_W-1:0];
  end

  assign pair_hit_o = |p_hit;
endmodule

// File: rtl/vsub_sum_unit.sv
module vsub_sum_unit #(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clr_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] res_o,
  output logic             sat_o
);
  import vsub_pkg::*;

  localparam int N_W = VEC_W / WORD_W;

  logic [N_SIZES-1:0][VEC_W-1:0] mod_v, ssat_v, usat_v;
  logic [N_SIZES-1:0]            ss_hit, us_hit;
  logic [VEC_W-1:0]              brw_v, all_v, pair_v, nxt_res;
  logic                          all_hit, pair_hit, nxt_hit;
  logic [1:0]                    sel;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
    localparam int LW = 8 << g;
    localparam int NL = VEC_W / LW;
    logic [NL-1:0] sh, uh;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      vsub_lane #(.W(LW)) u_lane (
        .a_i   (a_i[i*LW +: LW]),
        .b_i   (b_i[i*LW +: LW]),
        .mod_o (mod_v[g][i*LW +: LW]),
        .ssat_o(ssat_v[g][i*LW +: LW]),
        .usat_o(usat_v[g][i*LW +: LW]),
        .shit_o(sh[i]),
        .uhit_o(uh[i])
      );
    end
    assign ss_hit[g] = |sh;
    assign us_hit[g] = |uh;
  end

  for (genvar w = 0; w < N_W; w++) begin : g_nb
    assign brw_v[w*WORD_W +: WORD_W] =
      {{(WORD_W-1){1'b0}}, a_i[w*WORD_W +: WORD_W] >= b_i[w*WORD_W +: WORD_W]};
  end

  vsum_words #(.VEC_W(VEC_W)) u_sum (
    .a_i       (a_i),
    .b_i       (b_i),
    .all_o     (all_v),
    .all_hit_o (all_hit),
    .pair_o    (pair_v),
    .pair_hit_o(pair_hit)
  );

  assign sel = size_i[1] ? 2'd2 : {1'b0, size_i[0]};

  always_comb begin
    nxt_res = '0;
    nxt_hit = 1'b0;
    unique case (op_e'(op_i))
      OP_SUB_MOD:  nxt_res = mod_v[sel];
      OP_SUB_SSAT: begin nxt_res = ssat_v[sel]; nxt_hit = ss_hit[sel]; end
      OP_SUB_USAT: begin nxt_res = usat_v[sel]; nxt_hit = us_hit[sel]; end
      OP_SUB_NBRW: nxt_res = brw_v;
      OP_SUM_ALL:  begin nxt_res = all_v;  nxt_hit = all_hit;  end
      OP_SUM_PAIR: begin nxt_res = pair_v; nxt_hit = pair_hit; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      sat_o <= 1'b0;
    end else begin
      if (valid_i) res_o <= nxt_res;
      if (clr_i)                    sat_o <= 1'b0;
      else if (valid_i && nxt_hit)  sat_o <= 1'b1;
    end
  end

  // R8
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sat_o);
  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_i) |=> sat_o);
  // R7
  no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_o && !clr_i && (!valid_i || op_i == 3'd0 || op_i == 3'd3)) |=> !sat_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  // R4
  nbrw_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (res_o[WORD_W-1:1] == '0));
  // R5
  all_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (res_o[VEC_W-WORD_W-1:0] == '0));
  // R6
  pair_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5) |=> (res_o[WORD_W-1:0] == '0));
endmodule

// File: tb/sim_vsub_sum_unit.sv
module sim_vsub_sum_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;
  localparam int NV = 17;
  localparam int RW = 390;

  // {op, size, a, b, expected, flag}
  localparam logic [RW-1:0] VEC [NV] = '{
    {3'd0, 2'd0, {16{8'h05}}, {16{8'h07}}, {16{8'hFE}}, 1'b0},
    {3'd0, 2'd1, {8{16'h0001}}, {8{16'h0003}}, {8{16'hFFFE}}, 1'b0},
    {3'd0, 2'd2, {4{32'h0}}, {4{32'h1}}, {4{32'hFFFFFFFF}}, 1'b0},
    {3'd0, 2'd0, {16{8'h80}}, {16{8'h01}}, {16{8'h7F}}, 1'b0},
    {3'd1, 2'd0, {8{16'h8005}}, {16{8'h01}}, {8{16'h8004}}, 1'b1},
    {3'd1, 2'd0, {16{8'h7F}}, {16{8'hFF}}, {16{8'h7F}}, 1'b1},
    {3'd1, 2'd1, {8{16'h0010}}, {8{16'h0020}}, {8{16'hFFF0}}, 1'b0},
    {3'd1, 2'd3, {4{32'h80000000}}, {4{32'h1}}, {4{32'h80000000}}, 1'b1},
    {3'd2, 2'd0, {16{8'h05}}, {16{8'h07}}, {16{8'h00}}, 1'b1},
    {3'd2, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'hFFFE}}, 1'b0},
    {3'd2, 2'd2, {32'd1, 32'd3, 32'd1, 32'd3}, {4{32'd2}}, {32'd0, 32'd1, 32'd0, 32'd1}, 1'b1},
    {3'd3, 2'd0, {32'd5, 32'd5, 32'd4, 32'd0}, {32'd5, 32'd4, 32'd5, 32'd1}, {32'd1, 32'd1, 32'd0, 32'd0}, 1'b0},
    {3'd4, 2'd0, {4{32'd10}}, {32'd5, 32'd7, 32'd7, 32'd7}, {32'd45, 96'd0}, 1'b0},
    {3'd4, 2'd0, {4{32'h7FFFFFFF}}, {32'h7FFFFFFF, {3{32'h12345678}}}, {32'h7FFFFFFF, 96'd0}, 1'b1},
    {3'd4, 2'd0, {4{32'h80000000}}, {32'h80000000, 96'd0}, {32'h80000000, 96'd0}, 1'b1},
    {3'd5, 2'd0, {32'd4, 32'd3, 32'd2, 32'd1}, {32'd20, 32'd99, 32'd10, 32'd99}, {32'd27, 32'd0, 32'd13, 32'd0}, 1'b0},
    {3'd5, 2'd0, {32'h7FFFFFFF, 32'h7FFFFFFF, 32'd1, 32'd1}, {32'd1, 32'd0, 32'd1, 32'd0}, {32'h7FFFFFFF, 32'd0, 32'd3, 32'd0}, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         clr = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   size = '0;
  logic [127:0] a = '0;
  logic [127:0] b = '0;
  logic [127:0] res;
  logic         sat;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsub_sum_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr),
    .op_i(op), .size_i(size), .a_i(a), .b_i(b), .res_o(res), .sat_o(sat)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, results visible at the following falling edge
  task automatic step(input logic v, input logic c, input logic [2:0] o,
                      input logic [1:0] s, input logic [127:0] av, input logic [127:0] bv);
    @(negedge clk);
    valid = v; clr = c; op = o; size = s; a = av; b = bv;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10", res, '0);
    chk("R10", {127'd0, sat}, '0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(1'b0, 1'b1, 3'd0, 2'd0, '0, '0);
      step(1'b1, 1'b0, VEC[k][389:387], VEC[k][386:385], VEC[k][384:257], VEC[k][256:129]);
      chk(req_of(VEC[k][389:387]), res, VEC[k][128:1]);
      chk("R7", {127'd0, sat}, {127'd0, VEC[k][0]});
    end

    // R7 sticky across a non-clamping modulo op
    step(1'b1, 1'b0, 3'd1, 2'd0, {16{8'h7F}}, {16{8'hFF}});
    step(1'b1, 1'b0, 3'd0, 2'd0, {16{8'h05}}, {16{8'h07}});
    chk("R7", {127'd0, sat}, 128'd1);
    chk("R1", res, {16{8'hFE}});

    // R9 hold while valid low
    held = res;
    step(1'b0, 1'b0, 3'd2, 2'd1, {16{8'h33}}, {16{8'h11}});
    chk("R9", res, held);

    // R8 clear wins over simultaneous clamp; result still updates
    step(1'b1, 1'b1, 3'd2, 2'd0, {16{8'h05}}, {16{8'h07}});
    chk("R8", {127'd0, sat}, '0);
    chk("R3", res, {16{8'h00}});

    // R7 no-borrow op leaves cleared flag low
    step(1'b1, 1'b0, 3'd3, 2'd2, {4{32'd0}}, {4{32'hFFFFFFFF}});
    chk("R7", {127'd0, sat}, '0);
    chk("R4", res, '0);

    // R10 reset mid-run
    step(1'b1, 1'b0, 3'd1, 2'd0, {16{8'h80}}, {16{8'h01}});
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", res, '0);
    chk("R10", {127'd0, sat}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule